// File: doc/BRIEF.md
# Control-Flow Signature Watchdog

This block sits beside a processor and watches the instruction words that the processor fetches from memory. The program is cut into basic blocks, each a run of instructions closed by a branch. Each block opens with a marker no-op that carries the block's reference signature and its cycle budget. The last words before the closing branch are further marker no-ops, one for each block that the branch may legally reach. The watchdog folds every ordinary instruction word of a block into a running signature. When the branch arrives it compares the result with the reference. It then checks that the next block header is one of the recorded successors.

A per-block cycle budget catches loops that never end and a processor that stops fetching. If fetching starts inside a block, for example after reset or after a jump into the middle of a block, the checker throws away its partial state and waits for the next header. The result is a sticky error flag with a cause code. Both stay set until a synchronous clear.

Top module: `cfw_watchdog`

## Requirements
- R1: A fetched word is a marker when bits [31:26] equal 6'h3E. Bit 25 selects header (0) or successor (1). Bits [24:16] hold the cycle budget, which is used in headers only. Bits [15:0] hold the signature. Markers are never folded into the running signature.
- R2: The running signature is cleared to 0 at each accepted header. Each ordinary word x is reduced to c = x[15:0] ^ x[31:16]. With USE_LFSR=1 the next value is {s[14:0], ^(s & 16'hB400)} ^ c. With USE_LFSR=0 the next value is s | c.
- R3: The ordinary word fetched with blk_end high is folded as well. If the result differs from the header's signature, the flag rises with cause 1 (block signature) after that fetch's clock edge.
- R4: After a block ends, the next header's signature must equal one of the successor signatures recorded in that block. If it matches none, the flag rises with cause 2 (branch).
- R5: Up to MAX_SUCC successor markers are recorded per block, in arrival order. Further successor markers in the same block are dropped.
- R6: Words other than headers are ignored while the checker waits for a block. A header inside a block restarts checking from that header and discards the partial state. The first header after reset or clear is not branch-checked.
- R7: Count k = 1, 2, ... for the cycles after a header. A cycle in the block body with k-1 equal to the budget sets cause 3 (timeout), unless that cycle carries the closing branch or a new header. A branch in cycle budget+1 is therefore on time.
- R8: Once set, the flag and the first cause hold. All later fetches are ignored until err_clr.
- R9: err_clr is synchronous. On the next cycle the flag and cause read 0 and the checker waits for a header. It takes priority over an error detected in the same cycle.
- R10: After reset the flag and cause are 0.
- R11: A cycle with fetch_vld low changes no signature, no successor entry and no check, even with blk_end high. It still counts toward the budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_clr | input | 1 | Synchronous clear of the error flag and cause |
| fetch_vld | input | 1 | A fetched word is present this cycle |
| fetch_word | input | DATA_W | Fetched instruction word |
| blk_end | input | 1 | The fetched word is the branch that closes the block |
| err_flag | output | 1 | Sticky error flag |
| err_cause | output | 2 | 0 none, 1 block signature, 2 branch, 3 timeout |

## Verification
The bench builds two copies of the block. The main one uses the LFSR fold and two successor slots, so three successor markers in one block are enough to show that the third is dropped. The second uses the OR fold, which brings the saturating variant of the signature within reach. Because the budget field is only nine bits wide, blocks of a few words can place the timeout on the exact boundary cycle and on the cycle just before it.

// File: rtl/cfw_pkg.sv
package cfw_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_BODY  = 2'd1,
        ST_BRCHK = 2'd2,
        ST_ERR   = 2'd3
    } cfw_state_e;

    typedef enum logic [1:0] {
        CZ_NONE    = 2'd0,
        CZ_BLOCK   = 2'd1,
        CZ_BRANCH  = 2'd2,
        CZ_TIMEOUT = 2'd3
    } cfw_cause_e;

endpackage

// File: rtl/cfw_marker_decode.sv
module cfw_marker_decode #(
    parameter int DATA_W = 32,
    parameter int SIG_W  = 16,
    parameter int OP_W   = 6,
    parameter logic [OP_W-1:0] MARK_OP = 6'h3E,
    localparam int BUD_W = DATA_W - SIG_W - OP_W - 1
) (
    input  logic [DATA_W-1:0] word,
    output logic              is_mark,
    output logic              is_hdr,
    output logic              is_succ,
    output logic [SIG_W-1:0]  sig,
    output logic [BUD_W-1:0]  budget
);
    localparam int KIND_BIT = DATA_W - OP_W - 1;

    always_comb begin
        is_mark = (word[DATA_W-1 -: OP_W] == MARK_OP);
        is_hdr  = is_mark && !word[KIND_BIT];
        is_succ = is_mark &&  word[KIND_BIT];
        sig     = word[SIG_W-1:0];
        budget  = word[SIG_W +: BUD_W];
    end

endmodule

// File: rtl/cfw_sig_fold.sv
module cfw_sig_fold #(
    parameter int DATA_W = 32,
    parameter int SIG_W  = 16,
    parameter bit USE_LFSR = 1'b1,
    parameter logic [SIG_W-1:0] TAPS = 16'hB400
) (
    input  logic [SIG_W-1:0]  sig_cur,
    input  logic [DATA_W-1:0] word,
    output logic [SIG_W-1:0]  sig_nxt
);
    localparam int NCHUNK = DATA_W / SIG_W;

    logic [SIG_W-1:0] chunk;

    always_comb begin
        chunk = '0;
        for (int i = 0; i < NCHUNK; i++) begin
            chunk = chunk ^ word[i*SIG_W +: SIG_W];
        end
    end

    generate
        if (USE_LFSR) begin : g_lfsr
            logic fb;
            always_comb begin
                fb      = ^(sig_cur & TAPS);
                sig_nxt = {sig_cur[SIG_W-2:0], fb} ^ chunk;
            end
        end else begin : g_or
            always_comb begin
                sig_nxt = sig_cur | chunk;
            end
        end
    endgenerate

endmodule

// File: rtl/cfw_budget_timer.sv
module cfw_budget_timer #(
    parameter int BUD_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUD_W-1:0] limit,
    input  logic             run,
    output logic             expired
);
    logic [BUD_W-1:0] cnt_d, cnt_q;
    logic [BUD_W-1:0] lim_d, lim_q;

    always_comb begin
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        expired = (cnt_q == lim_q);
        if (load) begin
            cnt_d = '0;
            lim_d = limit;
        end else if (run && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            lim_q <= lim_d;
        end
    end

    // R7
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

    // R7
    tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == '0));

endmodule

// File: rtl/cfw_succ_table.sv
module cfw_succ_table #(
    parameter int SIG_W = 16,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [SIG_W-1:0] wr_sig,
    input  logic [SIG_W-1:0] probe,
    output logic             hit
);
    logic [DEPTH-1:0] vld_d, vld_q;
    logic [SIG_W-1:0] sig_d [DEPTH];
    logic [SIG_W-1:0] sig_q [DEPTH];
    logic [DEPTH-1:0] slot_hit;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            assign slot_hit[g] = vld_q[g] && (sig_q[g] == probe);
        end
    endgenerate

    assign hit = |slot_hit;

    always_comb begin
        logic placed;
        vld_d  = vld_q;
        placed = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            sig_d[i] = sig_q[i];
        end
        if (clr) begin
            vld_d = '0;
        end else if (wr) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!placed && !vld_q[i]) begin
                    vld_d[i] = 1'b1;
                    sig_d[i] = wr_sig;
                    placed   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                sig_q[i] <= '0;
            end
        end else begin
            vld_q <= vld_d;
            for (int i = 0; i < DEPTH; i++) begin
                sig_q[i] <= sig_d[i];
            end
        end
    end

    // R5
    succ_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((vld_q & (vld_q + 1'b1)) == '0));

    // R5
    succ_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&vld_q && wr && !clr) |=> ($stable(vld_q) && (sig_q[DEPTH-1] == $past(sig_q[DEPTH-1]))));

    // R6
    succ_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld_q == '0));

endmodule

// File: rtl/cfw_watchdog.sv
module cfw_watchdog
    import cfw_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SIG_W    = 16,
    parameter int OP_W     = 6,
    parameter logic [OP_W-1:0] MARK_OP = 6'h3E,
    parameter bit USE_LFSR = 1'b1,
    parameter logic [SIG_W-1:0] TAPS = 16'hB400,
    parameter int MAX_SUCC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_clr,
    input  logic              fetch_vld,
    input  logic [DATA_W-1:0] fetch_word,
    input  logic              blk_end,
    output logic              err_flag,
    output logic [1:0]        err_cause
);
    localparam int BUD_W = DATA_W - SIG_W - OP_W - 1;

    typedef struct packed {
        cfw_state_e       st;
        logic             flag;
        cfw_cause_e       cause;
        logic [SIG_W-1:0] acc;
        logic [SIG_W-1:0] refs;
    } wd_regs_t;

    wd_regs_t d, q;

    logic             m_mark, m_hdr, m_succ;
    logic [SIG_W-1:0] m_sig;
    logic [BUD_W-1:0] m_bud;
    logic [SIG_W-1:0] fold_out;
    logic             tmr_load, tmr_run, tmr_exp;
    logic             tbl_clr, tbl_wr, tbl_hit;
    logic             f_hdr, f_succ, f_brk, f_ins;

    cfw_marker_decode #(
        .DATA_W(DATA_W), .SIG_W(SIG_W), .OP_W(OP_W), .MARK_OP(MARK_OP)
    ) u_dec (
        .word(fetch_word), .is_mark(m_mark), .is_hdr(m_hdr),
        .is_succ(m_succ), .sig(m_sig), .budget(m_bud)
    );

    cfw_sig_fold #(
        .DATA_W(DATA_W), .SIG_W(SIG_W), .USE_LFSR(USE_LFSR), .TAPS(TAPS)
    ) u_fold (
        .sig_cur(q.acc), .word(fetch_word), .sig_nxt(fold_out)
    );

    cfw_budget_timer #(.BUD_W(BUD_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .limit(m_bud),
        .run(tmr_run), .expired(tmr_exp)
    );

    cfw_succ_table #(.SIG_W(SIG_W), .DEPTH(MAX_SUCC)) u_tbl (
        .clk(clk), .rst_n(rst_n), .clr(tbl_clr), .wr(tbl_wr),
        .wr_sig(m_sig), .probe(m_sig), .hit(tbl_hit)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tbl_clr  = 1'b0;
        tbl_wr   = 1'b0;
        tmr_run  = (q.st == ST_BODY);
        f_hdr    = fetch_vld && m_hdr;
        f_succ   = fetch_vld && m_succ;
        f_ins    = fetch_vld && !m_mark;
        f_brk    = f_ins && blk_end;

        if (err_clr) begin
            d.st    = ST_WAIT;
            d.flag  = 1'b0;
            d.cause = CZ_NONE;
            tbl_clr = 1'b1;
        end else begin
            case (q.st)
                ST_WAIT: begin
                    if (f_hdr) begin
                        d.st     = ST_BODY;
                        d.acc    = '0;
                        d.refs   = m_sig;
                        tmr_load = 1'b1;
                        tbl_clr  = 1'b1;
                    end
                end
                ST_BODY: begin
                    if (f_hdr) begin
                        d.acc    = '0;
                        d.refs   = m_sig;
                        tmr_load = 1'b1;
                        tbl_clr  = 1'b1;
                    end else if (f_brk) begin
                        if (fold_out != q.refs) begin
                            d.st    = ST_ERR;
                            d.flag  = 1'b1;
                            d.cause = CZ_BLOCK;
                        end else begin
                            d.st = ST_BRCHK;
                        end
                    end else begin
                        if (f_ins)  d.acc  = fold_out;
                        if (f_succ) tbl_wr = 1'b1;
                        if (tmr_exp) begin
                            d.st    = ST_ERR;
                            d.flag  = 1'b1;
                            d.cause = CZ_TIMEOUT;
                        end
                    end
                end
                ST_BRCHK: begin
                    if (f_hdr) begin
                        if (tbl_hit) begin
                            d.st     = ST_BODY;
                            d.acc    = '0;
                            d.refs   = m_sig;
                            tmr_load = 1'b1;
                            tbl_clr  = 1'b1;
                        end else begin
                            d.st    = ST_ERR;
                            d.flag  = 1'b1;
                            d.cause = CZ_BRANCH;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_WAIT;
            q.flag  <= 1'b0;
            q.cause <= CZ_NONE;
            q.acc   <= '0;
            q.refs  <= '0;
        end else begin
            q <= d;
        end
    end

    assign err_flag  = q.flag;
    assign err_cause = q.cause;

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> (err_flag && $stable(err_cause)));

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (!err_flag && (err_cause == 2'd0) && (q.st == ST_WAIT)));

    // R3
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag == (err_cause != 2'd0));

    // R11
    raise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> ($past(fetch_vld) || ($past(q.st) == ST_BODY)));

    // R6
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_WAIT) && !err_clr) |=> !err_flag);

endmodule

// File: tb/tb_cfw_watchdog.sv
module tb_cfw_watchdog;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [1:0]  v, e, c;
    logic [31:0] w0, w1;
    logic [1:0]  fl;
    logic [1:0]  cz0, cz1;
    int checks = 0;
    int errs   = 0;

    cfw_watchdog #(.USE_LFSR(1'b1), .MAX_SUCC(2)) dut (
        .clk(clk), .rst_n(rst_n), .err_clr(c[0]), .fetch_vld(v[0]),
        .fetch_word(w0), .blk_end(e[0]), .err_flag(fl[0]), .err_cause(cz0));

    cfw_watchdog #(.USE_LFSR(1'b0), .MAX_SUCC(2)) dut_or (
        .clk(clk), .rst_n(rst_n), .err_clr(c[1]), .fetch_vld(v[1]),
        .fetch_word(w1), .blk_end(e[1]), .err_flag(fl[1]), .err_cause(cz1));

    function automatic logic [15:0] fold(int u, logic [15:0] s, logic [31:0] x);
        logic [15:0] ch;
        ch = x[15:0] ^ x[31:16];
        if (u == 0) return {s[14:0], ^(s & 16'hB400)} ^ ch;
        return s | ch;
    endfunction

    function automatic logic [31:0] mk_hdr(logic [15:0] s, logic [8:0] b);
        return {6'h3E, 1'b0, b, s};
    endfunction

    function automatic logic [31:0] mk_succ(logic [15:0] s);
        return {6'h3E, 1'b1, 9'd0, s};
    endfunction

    function automatic logic [31:0] body_word();
        logic [31:0] x;
        x = $urandom;
        if (x[31:26] == 6'h3E) x[31] = 1'b0;
        return x;
    endfunction

    task automatic drv(int u, bit vv, logic [31:0] ww, bit ee, bit cc);
        if (u == 0) begin v[0] = vv; w0 = ww; e[0] = ee; c[0] = cc; end
        else        begin v[1] = vv; w1 = ww; e[1] = ee; c[1] = cc; end
        @(negedge clk);
        v = '0; e = '0; c = '0;
    endtask

    task automatic idle(int u, int n);
        for (int i = 0; i < n; i++) drv(u, 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic clr(int u);
        drv(u, 1'b0, 32'h0, 1'b0, 1'b1);
    endtask

    task automatic chk(int u, bit ef, logic [1:0] ec, string tag);
        logic gf;
        logic [1:0] gc;
        gf = fl[u];
        gc = (u == 0) ? cz0 : cz1;
        checks++;
        if (gf !== ef || gc !== ec) begin
            errs++;
            $display("FAIL %s dut%0d: flag=%0d cause=%0d expected flag=%0d cause=%0d",
                     tag, u, gf, gc, ef, ec);
        end
    endtask

    // kind: 0 good, 1 bad block signature, 2 bad branch, 3 timeout
    task automatic run_case(int u, int kind, bit pre, string tag);
        logic [31:0] sw[$];
        bit sv[$];
        bit se[$];
        logic [15:0] suc[$];
        logic [15:0] s, refv, nxt, sg;
        logic [31:0] x;
        int nb, ns, n;
        logic [8:0] bud;
        clr(u);
        if (pre) begin
            // R6: junk in wait state, then a header followed by a mid-block restart
            drv(u, 1'b1, body_word(), 1'b1, 1'b0);
            drv(u, 1'b1, mk_succ(16'h1234), 1'b0, 1'b0);
            drv(u, 1'b1, mk_hdr(16'hDEAD, 9'd2), 1'b0, 1'b0);
            drv(u, 1'b1, body_word(), 1'b0, 1'b0);
            drv(u, 1'b1, body_word(), 1'b0, 1'b0);
        end
        s  = '0;
        nb = 1 + $urandom % 6;
        ns = 1 + $urandom % 2;
        for (int i = 0; i < nb; i++) begin
            if ($urandom % 4 == 0) begin
                // R11: idle cycle, possibly with blk_end high
                sw.push_back($urandom); sv.push_back(1'b0); se.push_back($urandom % 2);
            end
            x = body_word();
            s = fold(u, s, x);
            sw.push_back(x); sv.push_back(1'b1); se.push_back(1'b0);
        end
        for (int i = 0; i < ns; i++) begin
            sg = $urandom;
            if (i == 1 && sg == suc[0]) sg = sg ^ 16'h1;
            suc.push_back(sg);
            sw.push_back(mk_succ(sg)); sv.push_back(1'b1); se.push_back(1'b0);
        end
        x = body_word();
        s = fold(u, s, x);
        sw.push_back(x); sv.push_back(1'b1); se.push_back(1'b1);
        n = sw.size();
        if (kind == 3) bud = 9'($urandom % (n - 1));
        else           bud = 9'(n - 1 + $urandom % 4);
        refv = (kind == 1) ? (s ^ (16'h1 << ($urandom % 16))) : s;
        drv(u, 1'b1, mk_hdr(refv, bud), 1'b0, 1'b0);
        for (int i = 0; i < n; i++) drv(u, sv[i], sw[i], se[i], 1'b0);
        if (kind == 2) begin
            nxt = $urandom;
            while (nxt == suc[0] || nxt == suc[ns-1]) nxt = nxt + 16'h1;
        end else begin
            nxt = suc[$urandom % ns];
        end
        drv(u, 1'b1, mk_hdr(nxt, 9'd50), 1'b0, 1'b0);
        idle(u, 1);
        case (kind)
            0: chk(u, 1'b0, 2'd0, {tag, " R1 R2 R3 R4 good"});
            1: chk(u, 1'b1, 2'd1, {tag, " R3 block sig"});
            2: chk(u, 1'b1, 2'd2, {tag, " R4 branch"});
            default: chk(u, 1'b1, 2'd3, {tag, " R7 timeout"});
        endcase
    endtask

    initial begin
        #(200000 * 10);
        errs++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        logic [15:0] s;
        void'($urandom(32'd20240611));
        v = '0; e = '0; c = '0; w0 = '0; w1 = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R10
        chk(0, 1'b0, 2'd0, "R10 reset");
        chk(1, 1'b0, 2'd0, "R10 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R6: resync paths
        run_case(0, 0, 1'b1, "R6 resync");
        run_case(0, 1, 1'b1, "R6 resync");

        // R5: overflow drops the third successor
        for (int t = 0; t < 2; t++) begin
            clr(0);
            a = body_word(); b = body_word();
            s = fold(0, fold(0, 16'h0, a), b);
            drv(0, 1'b1, mk_hdr(s, 9'd40), 1'b0, 1'b0);
            drv(0, 1'b1, a, 1'b0, 1'b0);
            drv(0, 1'b1, mk_succ(16'h1111), 1'b0, 1'b0);
            drv(0, 1'b1, mk_succ(16'h2222), 1'b0, 1'b0);
            drv(0, 1'b1, mk_succ(16'h3333), 1'b0, 1'b0);
            drv(0, 1'b1, b, 1'b1, 1'b0);
            drv(0, 1'b1, mk_hdr(t == 0 ? 16'h3333 : 16'h2222, 9'd40), 1'b0, 1'b0);
            if (t == 0) chk(0, 1'b1, 2'd2, "R5 third successor dropped");
            else        chk(0, 1'b0, 2'd0, "R5 second successor kept");
        end

        // R7: exact budget boundary, block of 5 fetch cycles
        for (int t = 0; t < 2; t++) begin
            logic [31:0] ws [5];
            clr(0);
            s = '0;
            for (int i = 0; i < 5; i++) begin ws[i] = body_word(); s = fold(0, s, ws[i]); end
            drv(0, 1'b1, mk_hdr(s, t == 0 ? 9'd4 : 9'd3), 1'b0, 1'b0);
            for (int i = 0; i < 5; i++) begin
                drv(0, 1'b1, ws[i], i == 4, 1'b0);
                if (t == 1 && i == 2) chk(0, 1'b0, 2'd0, "R7 before limit");
                if (t == 1 && i == 3) chk(0, 1'b1, 2'd3, "R7 at limit");
            end
            if (t == 0) chk(0, 1'b0, 2'd0, "R7 branch on last allowed cycle");
        end

        // R8: first cause kept
        clr(0);
        drv(0, 1'b1, mk_hdr(16'hBEEF, 9'd40), 1'b0, 1'b0);
        a = body_word();
        if (fold(0, 16'h0, a) == 16'hBEEF) a = a ^ 32'h1;
        drv(0, 1'b1, a, 1'b1, 1'b0);
        chk(0, 1'b1, 2'd1, "R3 single-word block mismatch");
        drv(0, 1'b1, mk_hdr(16'h0BAD, 9'd0), 1'b0, 1'b0);
        idle(0, 20);
        chk(0, 1'b1, 2'd1, "R8 sticky first cause");
        // R9
        clr(0);
        chk(0, 1'b0, 2'd0, "R9 clear");

        // R9: clear wins over a same-cycle mismatch
        drv(0, 1'b1, mk_hdr(16'hBEEF, 9'd40), 1'b0, 1'b0);
        drv(0, 1'b1, a, 1'b1, 1'b1);
        chk(0, 1'b0, 2'd0, "R9 clear priority");
        drv(0, 1'b1, a, 1'b1, 1'b0);
        chk(0, 1'b0, 2'd0, "R9 waits for header after clear");

        // R11: invalid cycle with blk_end does not close the block
        clr(0);
        a = body_word();
        s = fold(0, 16'h0, a);
        drv(0, 1'b1, mk_hdr(s, 9'd40), 1'b0, 1'b0);
        drv(0, 1'b0, body_word(), 1'b1, 1'b0);
        drv(0, 1'b0, mk_succ(16'h7777), 1'b0, 1'b0);
        drv(0, 1'b1, mk_succ(16'h5555), 1'b0, 1'b0);
        drv(0, 1'b1, a, 1'b1, 1'b0);
        chk(0, 1'b0, 2'd0, "R11 invalid fetch ignored");
        drv(0, 1'b1, mk_hdr(16'h7777, 9'd40), 1'b0, 1'b0);
        chk(0, 1'b1, 2'd2, "R11 invalid successor not recorded");

        // R2: OR fold directed
        clr(1);
        drv(1, 1'b1, mk_hdr(16'h0003, 9'd40), 1'b0, 1'b0);
        drv(1, 1'b1, 32'h0000_0001, 1'b0, 1'b0);
        drv(1, 1'b1, mk_succ(16'h00F0), 1'b0, 1'b0);
        drv(1, 1'b1, 32'h0002_0000, 1'b1, 1'b0);
        drv(1, 1'b1, mk_hdr(16'h00F0, 9'd40), 1'b0, 1'b0);
        chk(1, 1'b0, 2'd0, "R2 OR fold match");
        drv(1, 1'b1, 32'h0001_0003, 1'b1, 1'b0);
        chk(1, 1'b1, 2'd1, "R2 OR fold mismatch");

        // random mix
        for (int i = 0; i < 160; i++) run_case(0, $urandom % 4, ($urandom % 5) == 0, "rand lfsr");
        for (int i = 0; i < 40; i++)  run_case(1, $urandom % 4, 1'b0, "rand or");

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule